// File: doc/BRIEF.md
# Hamming Page ECC Generator

This block computes a 3-byte single-error-correcting Hamming code over a block of 256 data bytes. The bytes arrive one per accepted beat. The block accepts a byte on every cycle with no stall. It reads each byte once, so the data path needs no buffer.

Each byte is used in two ways:

- **Column parity.** Six parity bits are formed from fixed groups of bit positions. These six bits are XOR-folded over the whole block.
- **Line parity.** If a byte has odd parity, its index is folded into one 8-bit register. The complement of the index is folded into a second 8-bit register.

After the last byte is accepted, the two line-parity words are inverted and interleaved into two code bytes. The six column parities are inverted and packed, with two constant-one padding bits, into the third code byte. A done pulse marks the new code.

A read or write controller streams a data page through the block in 256-byte slices. It collects the code on each done pulse. Error correction and placement of the code in the spare area are handled elsewhere.

Top module: `hamming_page_ecc`

## Requirements
- R1: While reset is active, and after it is released, `done_o` is 0 and the three code outputs read 0xFF, 0xFF, 0xFF.
- R2: A high `start_i` discards any partial block and restarts at byte index 0. If `byte_vld_i` is also high in that cycle, that byte becomes index 0 of the new block.
- R3: A byte is accepted only in a cycle where `byte_vld_i` is high. Idle cycles do not advance the byte index and do not change any parity state.
- R4: `done_o` is high for exactly one cycle, the cycle after the 256th accepted byte. It is never high at any other time.
- R5: Column parities are defined over bits b0..b7 of each byte:
  - P0 is the XOR of b0, b2, b4 and b6; P1 is the XOR of b1, b3, b5 and b7.
  - P2 is the XOR of b0, b1, b4 and b5; P3 is the XOR of b2, b3, b6 and b7.
  - P4 is the XOR of b0..b3; P5 is the XOR of b4..b7.
  - `ecc2_o` bits 7..2 hold the inverted block-wide XOR of P5..P0, in that order. Bits 1..0 are always 1.
- R6: Let L be the XOR of the indices of all odd-parity bytes, and M the XOR of their bitwise complements.
  - Code word X is the inverse of {L7,M7,L6,M6,L5,M5,L4,M4}, MSB first.
  - Code word Y is the inverse of {L3,M3,L2,M2,L1,M1,L0,M0}, MSB first.
- R7: `swap_i` is sampled on the beat that accepts byte 255. If it is 0, `ecc0_o`=X and `ecc1_o`=Y. If it is 1, `ecc0_o`=Y and `ecc1_o`=X.
- R8: After byte 255 is accepted, the index wraps to 0 and all parity state clears. A following block may start on the very next cycle, with no `start_i`.
- R9: The code outputs hold their value between done pulses.
- R10: A block of 256 zero bytes gives the code 0xFF, 0xFF, 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Restart block at index 0 |
| byte_vld_i | input | 1 | Data byte valid this cycle |
| byte_i | input | 8 | Data byte |
| swap_i | input | 1 | Code byte order select |
| ecc0_o | output | 8 | First line-parity code byte |
| ecc1_o | output | 8 | Second line-parity code byte |
| ecc2_o | output | 8 | Column-parity code byte with padding |
| done_o | output | 1 | One-cycle pulse when a new code is valid |

## Verification
A wrong byte index or a lost accumulator clear stays hidden until the end of the block. It then shows as a wrong code byte, or a misplaced done pulse, in the cycle after byte 255. Such faults are therefore exposed once per 256 beats.

The bench uses single odd-parity bytes at chosen indices, so each line-parity bit can be traced to one code bit. It uses bursts with idle gaps and back-to-back blocks to expose counter drift. It uses restarts in mid-block to expose stale state leaking into the next code.

// File: rtl/hecc_pkg.sv
package hecc_pkg;
   localparam int unsigned BYTE_W     = 8;
   localparam int unsigned CODE_BYTES = 3;
   localparam logic [BYTE_W-1:0] CODE_IDLE = '1;
   typedef logic [BYTE_W-1:0] code_byte_t;
endpackage

// File: rtl/hecc_col_par.sv
module hecc_col_par #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CP_W   = 2 * $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [CP_W-1:0]   cp_o,
   output logic              odd_o
);
   localparam int unsigned SEL_W = $clog2(DATA_W);

   if ((1 << SEL_W) != DATA_W || DATA_W < 2) begin : g_bad_width
      $error("hecc_col_par: DATA_W must be a power of two");
   end
   if (CP_W != 2 * SEL_W) begin : g_bad_cp
      $error("hecc_col_par: CP_W must be twice log2(DATA_W)");
   end

   // mask of bit positions whose address bit k is one
   function automatic logic [DATA_W-1:0] hi_mask(input int k);
      logic [DATA_W-1:0] m;
      for (int b = 0; b < DATA_W; b++) m[b] = ((b >> k) & 1) == 1;
      return m;
   endfunction

   for (genvar k = 0; k < SEL_W; k++) begin : g_pair
      localparam logic [DATA_W-1:0] HI = hi_mask(k);
      assign cp_o[2*k]   = ^(data_i & ~HI);
      assign cp_o[2*k+1] = ^(data_i & HI);
   end

   assign odd_o = ^data_i;
endmodule

// File: rtl/hecc_beat_ctr.sv
module hecc_beat_ctr #(
   parameter int unsigned BLOCK_BYTES = 256,
   parameter int unsigned IDX_W       = $clog2(BLOCK_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             vld_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             last_o
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLOCK_BYTES - 1);

   if ((1 << IDX_W) != BLOCK_BYTES) begin : g_bad_block
      $error("hecc_beat_ctr: BLOCK_BYTES must equal 2**IDX_W");
   end

   logic [IDX_W-1:0] idx_q;

   // index of the byte on the bus this cycle
   assign idx_o  = start_i ? '0 : idx_q;
   assign last_o = vld_i && (idx_o == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      idx_q <= '0;
      else if (vld_i)  idx_q <= idx_o + 1'b1;
      else if (start_i) idx_q <= '0;
   end

   p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && !vld_i) |=> $stable(idx_q));
   p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !vld_i) |=> (idx_q == '0));
   p_restart_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && vld_i) |=> (idx_q == IDX_W'(1)));
   p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |=> (idx_q == '0));
endmodule

// File: rtl/hecc_accum.sv
module hecc_accum #(
   parameter int unsigned CP_W   = 6,
   parameter int unsigned IDX_W  = 8,
   parameter bit          KEEP_B = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             beat_i,
   input  logic             last_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic [CP_W-1:0]  cp_i,
   input  logic             odd_i,
   output logic [CP_W-1:0]  fin_cp_o,
   output logic [IDX_W-1:0] fin_a_o,
   output logic [IDX_W-1:0] fin_b_o
);
   logic [CP_W-1:0]  cp_q;
   logic [IDX_W-1:0] a_q;
   logic             hit;
   logic             wipe;

   assign hit  = beat_i && odd_i;
   assign wipe = beat_i && last_i;

   // running totals including this beat; the packer loads them on the last beat
   always_comb begin
      fin_cp_o = (clr_i ? '0 : cp_q) ^ (beat_i ? cp_i : '0);
      fin_a_o  = (clr_i ? '0 : a_q) ^ (hit ? idx_i : '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cp_q <= '0;
         a_q  <= '0;
      end else if (wipe) begin
         cp_q <= '0;
         a_q  <= '0;
      end else begin
         cp_q <= fin_cp_o;
         a_q  <= fin_a_o;
      end
   end

   if (KEEP_B) begin : g_b_reg
      logic [IDX_W-1:0] b_q;
      assign fin_b_o = (clr_i ? '0 : b_q) ^ (hit ? ~idx_i : '0);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    b_q <= '0;
         else if (wipe) b_q <= '0;
         else           b_q <= fin_b_o;
      end
   end else begin : g_b_derived
      // complement word = index word xor (odd-byte count parity replicated)
      logic p_q;
      logic p_sum;
      assign p_sum   = (clr_i ? 1'b0 : p_q) ^ hit;
      assign fin_b_o = fin_a_o ^ {IDX_W{p_sum}};
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    p_q <= 1'b0;
         else if (wipe) p_q <= 1'b0;
         else           p_q <= p_sum;
      end
   end

   p_clear_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wipe |=> (cp_q == '0 && a_q == '0));
   p_idle_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!beat_i && !clr_i) |=> ($stable(cp_q) && $stable(a_q)));
endmodule

// File: rtl/hecc_pack.sv
module hecc_pack #(
   parameter int unsigned CP_W   = 6,
   parameter int unsigned IDX_W  = 8,
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              swap_i,
   input  logic [CP_W-1:0]   cp_i,
   input  logic [IDX_W-1:0]  a_i,
   input  logic [IDX_W-1:0]  b_i,
   output logic [BYTE_W-1:0] ecc0_o,
   output logic [BYTE_W-1:0] ecc1_o,
   output logic [BYTE_W-1:0] ecc2_o,
   output logic              done_o
);
   localparam int unsigned PAD_W = BYTE_W - CP_W;

   if (IDX_W != BYTE_W) begin : g_bad_idx
      $error("hecc_pack: index width must equal code byte width");
   end
   if (CP_W >= BYTE_W) begin : g_bad_pad
      $error("hecc_pack: column parity must leave room for padding");
   end

   logic [2*IDX_W-1:0] line_w;
   logic [BYTE_W-1:0]  word_x, word_y, word_c;

   for (genvar j = 0; j < IDX_W; j++) begin : g_ilv
      assign line_w[2*j+1] = a_i[j];
      assign line_w[2*j]   = b_i[j];
   end

   assign word_x = ~line_w[2*IDX_W-1:IDX_W];
   assign word_y = ~line_w[IDX_W-1:0];
   assign word_c = {~cp_i, {PAD_W{1'b1}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ecc0_o <= '1;
         ecc1_o <= '1;
         ecc2_o <= '1;
         done_o <= 1'b0;
      end else begin
         done_o <= load_i;
         if (load_i) begin
            ecc0_o <= swap_i ? word_y : word_x;
            ecc1_o <= swap_i ? word_x : word_y;
            ecc2_o <= word_c;
         end
      end
   end

   p_done_follows_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> done_o);
   p_done_only_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> !done_o);
   p_code_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> ($stable(ecc0_o) && $stable(ecc1_o) && $stable(ecc2_o)));
   p_pad_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (ecc2_o[PAD_W-1:0] == '1));
endmodule

// File: rtl/hamming_page_ecc.sv
module hamming_page_ecc
   import hecc_pkg::*;
#(
   parameter int unsigned BLOCK_BYTES = 256,
   parameter bit          KEEP_B      = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              byte_vld_i,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic              swap_i,
   output logic [BYTE_W-1:0] ecc0_o,
   output logic [BYTE_W-1:0] ecc1_o,
   output logic [BYTE_W-1:0] ecc2_o,
   output logic              done_o
);
   localparam int unsigned IDX_W = $clog2(BLOCK_BYTES);
   localparam int unsigned CP_W  = 2 * $clog2(BYTE_W);

   if (IDX_W != BYTE_W) begin : g_bad_layout
      $error("hamming_page_ecc: line parity layout needs 2**BYTE_W bytes");
   end
   if (CODE_BYTES != 3) begin : g_bad_code
      $error("hamming_page_ecc: code must be three bytes");
   end

   logic [IDX_W-1:0] idx;
   logic             last;
   logic [CP_W-1:0]  cp, fin_cp;
   logic             odd;
   logic [IDX_W-1:0] fin_a, fin_b;

   hecc_beat_ctr #(.BLOCK_BYTES(BLOCK_BYTES), .IDX_W(IDX_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .vld_i(byte_vld_i),
      .idx_o(idx), .last_o(last)
   );

   hecc_col_par #(.DATA_W(BYTE_W), .CP_W(CP_W)) u_cpar (
      .data_i(byte_i), .cp_o(cp), .odd_o(odd)
   );

   hecc_accum #(.CP_W(CP_W), .IDX_W(IDX_W), .KEEP_B(KEEP_B)) u_acc (
      .clk(clk), .rst_n(rst_n), .clr_i(start_i), .beat_i(byte_vld_i),
      .last_i(last), .idx_i(idx), .cp_i(cp), .odd_i(odd),
      .fin_cp_o(fin_cp), .fin_a_o(fin_a), .fin_b_o(fin_b)
   );

   hecc_pack #(.CP_W(CP_W), .IDX_W(IDX_W), .BYTE_W(BYTE_W)) u_pack (
      .clk(clk), .rst_n(rst_n), .load_i(last), .swap_i(swap_i),
      .cp_i(fin_cp), .a_i(fin_a), .b_i(fin_b),
      .ecc0_o(ecc0_o), .ecc1_o(ecc1_o), .ecc2_o(ecc2_o), .done_o(done_o)
   );

   p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !done_o);
endmodule

// File: tb/tb_hamming_page_ecc.sv
module tb_hamming_page_ecc;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       vld = 1'b0;
   logic [7:0] din = '0;
   logic       swap = 1'b0;
   logic [7:0] ecc0, ecc1, ecc2;
   logic       done;

   int n_run  = 0;
   int n_fail = 0;
   logic [7:0] mem [256];

   always #4 clk = ~clk;

   hamming_page_ecc dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .byte_vld_i(vld),
      .byte_i(din), .swap_i(swap), .ecc0_o(ecc0), .ecc1_o(ecc1),
      .ecc2_o(ecc2), .done_o(done)
   );

   // pos, value, background, swap, expected {ecc0,ecc1,ecc2}
   localparam logic [48:0] VEC [8] = '{
      {8'd0,   8'h00, 8'h00, 1'b0, 24'hFFFFFF},
      {8'd0,   8'h01, 8'h00, 1'b0, 24'hAAAAAB},
      {8'd255, 8'h80, 8'h00, 1'b0, 24'h555557},
      {8'd15,  8'h01, 8'h00, 1'b0, 24'hAA55AB},
      {8'd15,  8'h01, 8'h00, 1'b1, 24'h55AAAB},
      {8'd5,   8'h03, 8'h00, 1'b0, 24'hFFFFF3},
      {8'd0,   8'hFE, 8'hFF, 1'b0, 24'hAAAAAB},
      {8'd0,   8'hFF, 8'hFF, 1'b1, 24'hFFFFFF}
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] model(input bit sw);
      logic [7:0] l = '0, m = '0, x, y;
      logic [5:0] p = '0;
      for (int i = 0; i < 256; i++) begin
         logic [7:0] d = mem[i];
         if (^d) begin l ^= 8'(i); m ^= ~8'(i); end
         p[0] ^= d[0] ^ d[2] ^ d[4] ^ d[6];
         p[1] ^= d[1] ^ d[3] ^ d[5] ^ d[7];
         p[2] ^= d[0] ^ d[1] ^ d[4] ^ d[5];
         p[3] ^= d[2] ^ d[3] ^ d[6] ^ d[7];
         p[4] ^= ^d[3:0];
         p[5] ^= ^d[7:4];
      end
      x = ~{l[7], m[7], l[6], m[6], l[5], m[5], l[4], m[4]};
      y = ~{l[3], m[3], l[2], m[2], l[1], m[1], l[0], m[0]};
      return sw ? {y, x, ~p, 2'b11} : {x, y, ~p, 2'b11};
   endfunction

   // swap is driven opposite on every beat but the last (R7 sampling point)
   task automatic feed(input bit first_start, input int gap, input bit sw,
                       input bit prev_chk, input logic [23:0] prev_exp);
      int early = 0;
      for (int i = 0; i < 256; i++) begin
         if (gap > 0 && i > 0 && (i % gap) == 0) begin
            @(negedge clk);
            vld = 1'b0; start = 1'b0;
            if (done) early++;
         end
         @(negedge clk);
         if (i == 0 && prev_chk) begin
            chk(done, "R8 back-to-back done", 32'(done), 32'd1);
            chk({ecc0, ecc1, ecc2} == prev_exp, "R8 first block code",
                32'({ecc0, ecc1, ecc2}), 32'(prev_exp));
         end else if (i > 0 && done) early++;
         start = first_start && (i == 0);
         vld   = 1'b1;
         din   = mem[i];
         swap  = (i == 255) ? sw : !sw;
      end
      chk(early == 0, "R4 no early done", 32'(early), 32'd0);
   endtask

   task automatic finish_block(input logic [23:0] exp, input string req);
      @(negedge clk);
      vld = 1'b0; start = 1'b0; swap = 1'b0;
      chk(done, "R4 done after last byte", 32'(done), 32'd1);
      chk({ecc0, ecc1, ecc2} == exp, req, 32'({ecc0, ecc1, ecc2}), 32'(exp));
      @(negedge clk);
      chk(!done, "R4 single-cycle done", 32'(done), 32'd0);
      chk({ecc0, ecc1, ecc2} == exp, "R9 code holds",
          32'({ecc0, ecc1, ecc2}), 32'(exp));
   endtask

   task automatic fill_random();
      for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      logic [23:0] e1;
      repeat (3) @(negedge clk);
      chk(!done && {ecc0, ecc1, ecc2} == 24'hFFFFFF, "R1 in reset",
          32'({done, ecc0, ecc1, ecc2}), 32'hFFFFFF);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!done && {ecc0, ecc1, ecc2} == 24'hFFFFFF, "R1 after reset",
          32'({done, ecc0, ecc1, ecc2}), 32'hFFFFFF);

      // table walk: R5 R6 R7 R10 (entry 0 is the all-zero block)
      for (int v = 0; v < 8; v++) begin
         for (int i = 0; i < 256; i++) mem[i] = VEC[v][32:25];
         mem[VEC[v][48:41]] = VEC[v][40:33];
         @(negedge clk); start = 1'b1; vld = 1'b0;
         feed(1'b0, 0, VEC[v][24], 1'b0, '0);
         finish_block(VEC[v][23:0], (v == 0) ? "R10 zero block" : "R5 R6 R7 vector");
      end

      // idle gaps inside a block: R3
      fill_random();
      feed(1'b0, 3, 1'b0, 1'b0, '0);
      finish_block(model(1'b0), "R3 gaps every 3");
      fill_random();
      feed(1'b0, 7, 1'b1, 1'b0, '0);
      finish_block(model(1'b1), "R3 gaps every 7");

      // back-to-back blocks without start: R8
      fill_random();
      e1 = model(1'b0);
      feed(1'b0, 0, 1'b0, 1'b0, '0);
      fill_random();
      feed(1'b0, 0, 1'b1, 1'b1, e1);
      finish_block(model(1'b1), "R8 second block");

      // restart with a byte in the same cycle: R2
      for (int i = 0; i < 100; i++) begin
         @(negedge clk); vld = 1'b1; din = 8'($urandom);
      end
      fill_random();
      feed(1'b1, 0, 1'b0, 1'b0, '0);
      finish_block(model(1'b0), "R2 start with byte");

      // restart in an idle cycle: R2
      for (int i = 0; i < 50; i++) begin
         @(negedge clk); vld = 1'b1; din = 8'($urandom);
      end
      @(negedge clk); vld = 1'b0; start = 1'b1;
      fill_random();
      feed(1'b0, 0, 1'b1, 1'b0, '0);
      finish_block(model(1'b1), "R2 start alone");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule